// File: doc/BRIEF.md
# Multi-Mode Pulse Event Counter

This block keeps a signed running tally of fast external pulse events that a slow polling controller could never sample reliably. A mode number, captured once by a definition strobe, chooses the counting front-end. The first is a single pulse input whose direction comes from a host control bit. The second is a single pulse input whose direction comes from a second external pin. The third is a pair of independent up and down pulse inputs. The fourth is a two-phase quadrature decoder running at 1x or 4x resolution. Within each front-end family, the mode number also chooses whether an external clear pin and an external start (gate) pin take part.

Every external pin passes through a two-flop synchronizer. Edges are detected on the system clock, and the count register changes on the third rising clock edge after a pin changes. The host can enable or disable counting, set the direction bit, pick the quadrature resolution and load an arbitrary count value at any time. Two instances share nothing, so each counts without any effect on the other.

Mode map (mode = 3 x family + variant). Families: 0-2 host direction, 3-5 pin direction, 6-8 dual pulse, 9-11 quadrature. Variants: +0 plain, +1 with clear pin, +2 with clear and start pins. Modes 12-15 never count.

Top module: `evt_counter`

## Requirements
- R1: After rst_ni is asserted low, count_o is 0 and quad_err_o is 0.
- R2: The first def_i pulse after reset latches mode_i, and later def_i pulses are ignored. Until the first def_i pulse, no pulse input changes count_o.
- R3: In modes 0-2, each rising edge on ph_a_i adds 1 when dir_i is 1 and subtracts 1 when dir_i is 0.
- R4: In modes 3-5, each rising edge on ph_a_i adds 1 when the synchronized level of ph_b_i is 1 and subtracts 1 when it is 0. dir_i has no effect in these modes.
- R5: In modes 6-8, a rising edge on ph_a_i adds 1 and a rising edge on ph_b_i subtracts 1. When both edges land in the same cycle, the count is unchanged.
- R6: In modes 9-11 with quad_x4_i=1, each step of the {A,B} sequence 00, 10, 11, 01, 00 adds 1, and each step in the reverse order subtracts 1.
- R7: In modes 9-11 with quad_x4_i=0, a full encoder cycle counts once. The step 01 to 00 adds 1, the step 00 to 01 subtracts 1, and all other steps leave the count alone.
- R8: In modes 9-11, a step in which A and B change together leaves the count unchanged and sets quad_err_o. quad_err_o then stays 1 until rst_ni.
- R9: In modes 1, 2, 4, 5, 7, 8, 10 and 11, a high level on ext_clr_i forces count_o to 0, with priority over load and counting. In the other modes, ext_clr_i is ignored.
- R10: In modes 2, 5, 8 and 11, events are counted only while start_i is high.
- R11: While en_i is 0, no event changes the count. A load_i pulse writes load_val_i into count_o on the next clock.
- R12: count_o is a W-bit two's-complement value that wraps on overflow and underflow (0x7FFFFFFF+1 gives 0x80000000, and 0-1 gives 0xFFFFFFFF).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| def_i | input | 1 | Definition strobe, latches mode_i once |
| mode_i | input | 4 | Mode number 0-11 |
| en_i | input | 1 | Host count enable |
| dir_i | input | 1 | Host direction bit, 1 = up |
| quad_x4_i | input | 1 | Quadrature resolution, 1 = 4x, 0 = 1x |
| load_i | input | 1 | Load strobe |
| load_val_i | input | W | Value written by load_i |
| ph_a_i | input | 1 | Pulse / up pulse / phase A pin |
| ph_b_i | input | 1 | Direction / down pulse / phase B pin |
| ext_clr_i | input | 1 | External clear pin |
| start_i | input | 1 | External start gate pin |
| count_o | output | W | Signed event count |
| quad_err_o | output | 1 | Sticky invalid quadrature step flag |

## Verification
The checker watches five things on every cycle. The count moves by at most one step unless a clear or load occurs. The latched mode never changes once defined. The count stays frozen before definition. A clear leads to zero, and a load leads to its value. The error flag never drops. The bench scenarios must show what a single cycle cannot: the direction each front-end picks, the cancellation of coincident dual pulses, the 1x and 4x quadrature counts over full encoder cycles, the gating by start and enable, and wrap-around at the signed limits.

// File: rtl/evt_cnt_pkg.sv
package evt_cnt_pkg;
  localparam int unsigned MODE_W = 4;

  typedef enum logic [1:0] {
    FAM_HOST_DIR = 2'd0,
    FAM_PIN_DIR  = 2'd1,
    FAM_DUAL     = 2'd2,
    FAM_QUAD     = 2'd3
  } fam_e;

  function automatic logic mode_valid(input logic [MODE_W-1:0] m);
    return m < 4'd12;
  endfunction

  function automatic fam_e mode_fam(input logic [MODE_W-1:0] m);
    if (m < 4'd3)      return FAM_HOST_DIR;
    else if (m < 4'd6) return FAM_PIN_DIR;
    else if (m < 4'd9) return FAM_DUAL;
    else               return FAM_QUAD;
  endfunction

  function automatic logic mode_has_clr(input logic [MODE_W-1:0] m);
    return mode_valid(m) && ((m % 4'd3) != 4'd0);
  endfunction

  function automatic logic mode_has_start(input logic [MODE_W-1:0] m);
    return mode_valid(m) && ((m % 4'd3) == 4'd2);
  endfunction

  // Gray position of {A,B}: 00,10,11,01 -> 0..3
  function automatic logic [1:0] quad_pos(input logic a, input logic b);
    case ({a, b})
      2'b00:   return 2'd0;
      2'b10:   return 2'd1;
      2'b11:   return 2'd2;
      default: return 2'd3;
    endcase
  endfunction
endpackage

// File: rtl/evt_sync.sv
module evt_sync #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= d_i[i];
        s2_q <= s1_q;
      end
    end
    assign q_o[i] = s2_q;
  end
endmodule

// File: rtl/evt_front.sv
module evt_front
  import evt_cnt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              defined_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              en_i,
  input  logic              dir_i,
  input  logic              x4_i,
  input  logic              a_i,
  input  logic              b_i,
  input  logic              clr_i,
  input  logic              start_i,
  output logic              up_o,
  output logic              dn_o,
  output logic              clr_o,
  output logic              qerr_o
);
  logic a_q, b_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= 1'b0;
      b_q <= 1'b0;
    end else begin
      a_q <= a_i;
      b_q <= b_i;
    end
  end

  logic rise_a, rise_b;
  assign rise_a = a_i & ~a_q;
  assign rise_b = b_i & ~b_q;

  fam_e fam;
  logic gate;
  assign fam  = mode_fam(mode_i);
  assign gate = defined_i & mode_valid(mode_i) & en_i
              & (~mode_has_start(mode_i) | start_i);

  logic [1:0] pos_old, pos_new;
  logic       moved, fwd, bwd;
  assign pos_old = quad_pos(a_q, b_q);
  assign pos_new = quad_pos(a_i, b_i);
  assign moved   = pos_new != pos_old;
  assign fwd     = pos_new == pos_old + 2'd1;
  assign bwd     = pos_new == pos_old - 2'd1;

  logic up, dn, bad;
  always_comb begin
    up  = 1'b0;
    dn  = 1'b0;
    bad = 1'b0;
    case (fam)
      FAM_HOST_DIR: begin
        up = rise_a & dir_i;
        dn = rise_a & ~dir_i;
      end
      FAM_PIN_DIR: begin
        up = rise_a & b_i;
        dn = rise_a & ~b_i;
      end
      FAM_DUAL: begin
        up = rise_a & ~rise_b;
        dn = rise_b & ~rise_a;
      end
      default: begin
        bad = moved & ~fwd & ~bwd;
        if (x4_i) begin
          up = fwd;
          dn = bwd;
        end else begin
          up = fwd & (pos_old == 2'd3);
          dn = bwd & (pos_old == 2'd0);
        end
      end
    endcase
  end

  assign up_o   = gate & up;
  assign dn_o   = gate & dn;
  assign qerr_o = gate & bad;
  assign clr_o  = defined_i & mode_has_clr(mode_i) & clr_i;
endmodule

// File: rtl/evt_counter.sv
module evt_counter
  import evt_cnt_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              def_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              en_i,
  input  logic              dir_i,
  input  logic              quad_x4_i,
  input  logic              load_i,
  input  logic [W-1:0]      load_val_i,
  input  logic              ph_a_i,
  input  logic              ph_b_i,
  input  logic              ext_clr_i,
  input  logic              start_i,
  output logic [W-1:0]      count_o,
  output logic              quad_err_o
);
  localparam int unsigned NPIN = 4;
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic              defined_q;
  logic [MODE_W-1:0] mode_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      defined_q <= 1'b0;
      mode_q    <= '0;
    end else if (def_i && !defined_q) begin
      defined_q <= 1'b1;
      mode_q    <= mode_i;
    end
  end

  logic [NPIN-1:0] pin_s;
  evt_sync #(.N(NPIN)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({start_i, ext_clr_i, ph_b_i, ph_a_i}),
    .q_o    (pin_s)
  );

  logic step_up, step_dn, clr_hit, qerr_hit;
  evt_front u_front (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .defined_i (defined_q),
    .mode_i    (mode_q),
    .en_i      (en_i),
    .dir_i     (dir_i),
    .x4_i      (quad_x4_i),
    .a_i       (pin_s[0]),
    .b_i       (pin_s[1]),
    .clr_i     (pin_s[2]),
    .start_i   (pin_s[3]),
    .up_o      (step_up),
    .dn_o      (step_dn),
    .clr_o     (clr_hit),
    .qerr_o    (qerr_hit)
  );

  logic [W-1:0] cnt_q;
  logic         err_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (clr_hit)      cnt_q <= '0;
      else if (load_i)  cnt_q <= load_val_i;
      else if (step_up) cnt_q <= cnt_q + ONE;
      else if (step_dn) cnt_q <= cnt_q - ONE;
      if (qerr_hit) err_q <= 1'b1;
    end
  end

  assign count_o    = cnt_q;
  assign quad_err_o = err_q;
endmodule

// File: rtl/evt_counter_chk.sv
module evt_counter_chk
  import evt_cnt_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              load_i,
  input logic [W-1:0]      load_val_i,
  input logic [W-1:0]      count_o,
  input logic              quad_err_o,
  input logic              defined_q,
  input logic [MODE_W-1:0] mode_q,
  input logic              clr_hit
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  AST_MODE_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    defined_q |=> $stable(mode_q)); // R2

  AST_IDLE_UNDEF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!defined_q && !load_i) |=> $stable(count_o)); // R2

  AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_hit |=> (count_o == '0)); // R9

  AST_LOAD_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !clr_hit) |=> (count_o == $past(load_val_i))); // R11

  AST_SINGLE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !clr_hit) |=> ((count_o == $past(count_o)) ||
                               (count_o == $past(count_o) + ONE) ||
                               (count_o == $past(count_o) - ONE))); // R12

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    quad_err_o |=> quad_err_o); // R8
endmodule

bind evt_counter evt_counter_chk #(.W(W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .load_i     (load_i),
  .load_val_i (load_val_i),
  .count_o    (count_o),
  .quad_err_o (quad_err_o),
  .defined_q  (defined_q),
  .mode_q     (mode_q),
  .clr_hit    (clr_hit)
);

// File: tb/sim_evt_counter.sv
module sim_evt_counter;
  localparam int W = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          def = 1'b0;
  logic [3:0]    mode = '0;
  logic          en = 1'b1;
  logic          dir = 1'b1;
  logic          x4 = 1'b1;
  logic          load = 1'b0;
  logic [W-1:0]  load_val = '0;
  logic          pa = 1'b0;
  logic          pb = 1'b0;
  logic          clr = 1'b0;
  logic          start = 1'b0;
  logic [W-1:0]  count;
  logic          qerr;

  always #2.5 clk = ~clk;

  evt_counter #(.W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .def_i(def), .mode_i(mode), .en_i(en),
    .dir_i(dir), .quad_x4_i(x4), .load_i(load), .load_val_i(load_val),
    .ph_a_i(pa), .ph_b_i(pb), .ext_clr_i(clr), .start_i(start),
    .count_o(count), .quad_err_o(qerr)
  );

  typedef struct {
    logic [W-1:0] cnt;
    logic         err;
    string        tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // monitor: pops expected items and compares after settling
  initial begin
    forever begin
      wait (q.size() != 0);
      repeat (4) @(negedge clk);
      begin
        item_t it;
        it = q.pop_front();
        checks++;
        if (count !== it.cnt || qerr !== it.err) begin
          errors++;
          $display("FAIL %s: count=%h err=%b expected count=%h err=%b",
                   it.tag, count, qerr, it.cnt, it.err);
        end
      end
    end
  end

  task automatic expect_st(input logic [W-1:0] v, input logic e, input string tag);
    q.push_back('{cnt: v, err: e, tag: tag});
    wait (q.size() == 0);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; def = 0; en = 1; dir = 1; x4 = 1; load = 0;
    pa = 0; pb = 0; clr = 0; start = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic define(input logic [3:0] m);
    @(negedge clk); def = 1; mode = m;
    @(negedge clk); def = 0;
  endtask

  task automatic pulse_a();
    @(negedge clk); pa = 1; settle(); pa = 0; settle();
  endtask

  task automatic pulse_b();
    @(negedge clk); pb = 1; settle(); pb = 0; settle();
  endtask

  task automatic pulse_ab();
    @(negedge clk); pa = 1; pb = 1; settle(); pa = 0; pb = 0; settle();
  endtask

  task automatic set_ab(input logic a, input logic b);
    @(negedge clk); pa = a; pb = b; settle();
  endtask

  task automatic do_load(input logic [W-1:0] v);
    @(negedge clk); load = 1; load_val = v;
    @(negedge clk); load = 0;
  endtask

  initial begin
    do_reset();
    expect_st(32'h0, 1'b0, "R1 reset state");

    pulse_a();
    expect_st(32'h0, 1'b0, "R2 no count before definition");

    define(4'd0);
    dir = 1;
    for (int i = 0; i < 3; i++) pulse_a();
    expect_st(32'd3, 1'b0, "R3 host dir up");
    dir = 0;
    pulse_a(); pulse_a();
    expect_st(32'd1, 1'b0, "R3 host dir down");

    define(4'd6);   // ignored, still mode 0
    pulse_b();
    pulse_a();
    expect_st(32'd0, 1'b0, "R2 second definition ignored");

    en = 0;
    pulse_a();
    expect_st(32'd0, 1'b0, "R11 enable low blocks");
    en = 1;
    do_load(32'd5);
    expect_st(32'd5, 1'b0, "R11 load value");

    do_load(32'h0);
    dir = 0; pulse_a();
    expect_st(32'hFFFF_FFFF, 1'b0, "R12 underflow wrap");
    do_load(32'h7FFF_FFFF);
    dir = 1; pulse_a();
    expect_st(32'h8000_0000, 1'b0, "R12 overflow wrap");

    @(negedge clk); clr = 1; settle(); clr = 0; settle();
    expect_st(32'h8000_0000, 1'b0, "R9 clear pin ignored in mode 0");

    // pin direction mode
    do_reset();
    define(4'd3);
    dir = 0;
    set_ab(1'b0, 1'b1);
    pulse_a(); pulse_a();
    expect_st(32'd2, 1'b0, "R4 pin dir up");
    dir = 1;
    set_ab(1'b0, 1'b0);
    pulse_a();
    expect_st(32'd1, 1'b0, "R4 pin dir down");

    // dual pulse mode with clear
    do_reset();
    define(4'd7);
    for (int i = 0; i < 3; i++) pulse_a();
    expect_st(32'd3, 1'b0, "R5 up pulses");
    pulse_b();
    expect_st(32'd2, 1'b0, "R5 down pulse");
    pulse_ab();
    expect_st(32'd2, 1'b0, "R5 coincident cancel");
    @(negedge clk); clr = 1; settle();
    pulse_a();
    expect_st(32'd0, 1'b0, "R9 clear holds zero");
    clr = 0; settle();

    // quadrature with clear and start
    do_reset();
    define(4'd11);
    x4 = 1; start = 0; settle();
    set_ab(1,0); set_ab(1,1); set_ab(0,1); set_ab(0,0);
    expect_st(32'd0, 1'b0, "R10 start low blocks");
    start = 1; settle();
    set_ab(1,0); set_ab(1,1); set_ab(0,1); set_ab(0,0);
    expect_st(32'd4, 1'b0, "R6 4x forward");
    set_ab(0,1); set_ab(1,1); set_ab(1,0); set_ab(0,0);
    expect_st(32'd0, 1'b0, "R6 4x reverse");
    x4 = 0;
    set_ab(1,0); set_ab(1,1); set_ab(0,1); set_ab(0,0);
    expect_st(32'd1, 1'b0, "R7 1x forward cycle");
    set_ab(0,1); set_ab(1,1); set_ab(1,0); set_ab(0,0);
    expect_st(32'd0, 1'b0, "R7 1x reverse cycle");
    set_ab(1,1);
    expect_st(32'd0, 1'b1, "R8 invalid step flagged");
    set_ab(1,0);
    expect_st(32'd0, 1'b1, "R8 flag sticky");

    do_reset();
    expect_st(32'd0, 1'b0, "R1 reset clears flag");

    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: count=%h err=%b expected completion", count, qerr);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule